// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Sequencer

This block steers the instruction stream of a small processor through a fetch, decode and execute pipeline. Instructions are one or two words long. The block reads one program word per cycle from a program memory that has one cycle of read latency. It tags each word as either an opcode or an extension word, where an extension word carries immediate data or an absolute address. It then moves the words down the pipeline so that the three stages work on consecutive words at the same time. An extension word gets its own slot in decode and in execute, so a two-word instruction spends two cycles in execute.

An external decoder looks at the word in decode and reports whether it is an opcode that brings an extension word with it. The execute side reports taken branches together with a target address. A branch is honoured only on the last slot of an instruction. It empties the younger stages, and fetching restarts at the target. A processing-state input tells the block whether the core is in its normal state. In any other state, every stage reads as empty and no fetch is issued. When the core returns to the normal state, fetching resumes just after the last instruction that completed.

Top module: `ipipe_seq`

## Requirements
- R1: While reset is held (active-low, sampled on the rising clock edge), and in the first cycle after it, the decode and execute stages are empty, instruction-complete is low, and the fetch address equals the reset vector 0x0000.
- R2: In the normal state (processing-state code 0), exactly one program word is requested per cycle. Unless a branch was taken in the previous cycle, the fetch address is one above the previous cycle's fetch address.
- R3: A word whose address is put out in cycle n is in decode in cycle n+1 and in execute in cycle n+2. After reset, the word at the reset vector is therefore in execute in the third cycle.
- R4: Once the pipeline is full and no branch or state change occurs, one slot reaches execute in every cycle, with addresses increasing by one.
- R5: When the decode slot holds a valid opcode and the decoder hint is high, the next word is tagged as an extension. In its own execute cycle, that extension is presented on the extension-word output, while the opcode output keeps its instruction's opcode.
- R6: The decoder hint has no effect while decode holds an extension word or is empty. The word after such a slot is tagged as an opcode.
- R7: Instruction-complete is high only on the last execute slot of an instruction: a one-word opcode, or an extension word. An opcode that is followed by an extension is never complete.
- R8: A branch taken while instruction-complete is high empties decode and execute at the next edge. The next fetch address is the target, and the target reaches execute three cycles after the branch cycle, leaving two empty execute cycles.
- R9: A branch request made while instruction-complete is low is ignored: fetch continues sequentially and decode is not emptied.
- R10: In any processing state other than normal (codes 1 exception, 2 reset, 3 wait, 4 stop), the read enable, decode valid, execute valid and instruction-complete outputs are low. On the first normal cycle afterwards, decode and execute are still empty.
- R11: On return to the normal state, fetching restarts at the address following the last completed instruction, or at that instruction's target if it branched. The restart instruction reaches execute two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pstate | input | 3 | Processing state: 0 normal, 1 exception, 2 reset, 3 wait, 4 stop |
| imem_addr | output | ADDR_W | Program memory fetch address |
| imem_rd | output | 1 | Program memory read enable |
| imem_rdata | input | WORD_W | Program word, one cycle after its address |
| dec_two_word | input | 1 | Decoder hint: the word in decode is an opcode with an extension |
| branch_taken | input | 1 | Control-flow change requested by the executing instruction |
| branch_target | input | ADDR_W | Address to resume fetching at on a taken branch |
| dec_valid | output | 1 | Decode slot holds a word |
| dec_is_ext | output | 1 | Decode slot is an extension word |
| dec_addr | output | ADDR_W | Address of the word in decode |
| ex_valid | output | 1 | Execute slot holds a word |
| ex_is_ext | output | 1 | Execute slot is an extension word |
| ex_addr | output | ADDR_W | Address of the word in execute |
| ex_opcode | output | WORD_W | Opcode of the instruction in execute |
| ex_ext_word | output | WORD_W | Extension word of the instruction in execute |
| ex_done | output | 1 | Execute slot is the last slot of its instruction |

## Verification
An address put out in cycle n shows up in decode in cycle n+1 and in execute in cycle n+2. So a straight program run after reset places address k-2 in execute once k rising edges have passed. A taken branch seen at the edge that ends cycle t puts the target address out in cycle t+1, and the target reaches execute in cycle t+3. Leaving the normal state silences the outputs in the same cycle, and the restart address appears in the first normal cycle. The bench drives its inputs and samples the outputs on falling edges. It counts rising edges from each stimulus and compares at exactly those edges against schedules worked out by hand for each program.

// File: rtl/ipipe_pkg.sv
// Package: shared types and helpers for the instruction pipeline sequencer.
// Assumes processing-state codes are fixed: 0 normal, 1..4 other states.
package ipipe_pkg;

    // Processing-state codes seen on the pstate input.
    typedef enum logic [2:0] {
        PS_NORMAL = 3'd0,
        PS_EXCEPT = 3'd1,
        PS_RESET  = 3'd2,
        PS_WAIT   = 3'd3,
        PS_STOP   = 3'd4
    } pstate_e;

    // Kind of word occupying a pipeline slot.
    typedef enum logic {
        TAG_OP  = 1'b0,
        TAG_EXT = 1'b1
    } slot_tag_e;

    // True when the core is in the normal processing state.
    function automatic logic is_normal(input logic [2:0] st);
        return pstate_e'(st) == PS_NORMAL;
    endfunction

endpackage

// File: rtl/ipipe_fetch.sv
// Module: fetch stage. Holds the next fetch address and the restart address.
// Assumes: run is high only in the normal state; redirect is asserted only
// together with a completing execute slot; commit_en marks such a slot.
module ipipe_fetch #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    input  logic              commit_en,
    input  logic [ADDR_W-1:0] commit_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_req
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] resume_q;

    // Restart pointer: address after the last completed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= RESET_VEC;
        end else if (commit_en) begin
            resume_q <= redirect ? redirect_pc : commit_addr + STEP;
        end
    end

    // Next fetch address: sequential, redirected, or rewound when halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_VEC;
        end else if (!run) begin
            pc_q <= resume_q;
        end else if (redirect) begin
            pc_q <= redirect_pc;
        end else begin
            pc_q <= pc_q + STEP;
        end
    end

    // One word requested per normal cycle, none during reset.
    always_comb begin
        fetch_addr = pc_q;
        fetch_req  = run && rst_n;
    end

endmodule

// File: rtl/ipipe_decode.sv
// Module: decode stage. Records which fetched word now sits in decode and
// whether it is an opcode or an extension word.
// Assumes: the program word itself arrives from memory during this stage;
// the decoder hint refers to that word.
module ipipe_decode
    import ipipe_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              two_word_hint,
    output logic              d_valid,
    output slot_tag_e         d_tag,
    output logic [ADDR_W-1:0] d_addr
);
    slot_tag_e next_tag;

    // The word after a valid opcode flagged by the hint is its extension.
    always_comb begin
        if (d_valid && d_tag == TAG_OP && two_word_hint) begin
            next_tag = TAG_EXT;
        end else begin
            next_tag = TAG_OP;
        end
    end

    // Decode slot register: load the fetched word, or empty on kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_valid <= 1'b0;
            d_tag   <= TAG_OP;
            d_addr  <= '0;
        end else if (!run || flush) begin
            d_valid <= 1'b0;
            d_tag   <= TAG_OP;
        end else begin
            d_valid <= fetch_req;
            d_tag   <= next_tag;
            d_addr  <= fetch_addr;
        end
    end

endmodule

// File: rtl/ipipe_exec.sv
// Module: execute stage. Holds the slot being executed, the opcode of its
// instruction and its extension word, and flags the instruction's last slot.
// Assumes: an extension slot always directly follows its opcode slot.
module ipipe_exec
    import ipipe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              flush,
    input  logic              d_valid,
    input  slot_tag_e         d_tag,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [WORD_W-1:0] d_word,
    input  logic              two_word_hint,
    output logic              e_valid,
    output logic              e_is_ext,
    output logic [ADDR_W-1:0] e_addr,
    output logic [WORD_W-1:0] e_opcode,
    output logic [WORD_W-1:0] e_ext_word,
    output logic              e_done
);
    logic              v_q;
    slot_tag_e         tag_q;
    logic              two_q;
    logic              advance;

    assign advance = run && !flush && d_valid;

    // Execute slot register: take the decode slot when it advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q        <= 1'b0;
            tag_q      <= TAG_OP;
            two_q      <= 1'b0;
            e_addr     <= '0;
            e_opcode   <= '0;
            e_ext_word <= '0;
        end else begin
            v_q <= advance;
            if (advance) begin
                e_addr <= d_addr;
                tag_q  <= d_tag;
                if (d_tag == TAG_OP) begin
                    e_opcode <= d_word;
                    two_q    <= two_word_hint;
                end else begin
                    e_ext_word <= d_word;
                end
            end
        end
    end

    // Visible slot state, silenced outside the normal state.
    always_comb begin
        e_valid  = v_q && run;
        e_is_ext = tag_q == TAG_EXT;
        e_done   = v_q && run && (tag_q == TAG_EXT || !two_q);
    end

endmodule

// File: rtl/ipipe_seq.sv
// Module: top of the three-stage pipeline sequencer. Wires fetch, decode
// and execute, derives the run and flush controls, and exposes the stages.
// Assumes: program memory returns the word one cycle after its address;
// branch requests come from the instruction shown in execute.
module ipipe_seq
    import ipipe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 24,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pstate,
    output logic [ADDR_W-1:0] imem_addr,
    output logic              imem_rd,
    input  logic [WORD_W-1:0] imem_rdata,
    input  logic              dec_two_word,
    input  logic              branch_taken,
    input  logic [ADDR_W-1:0] branch_target,
    output logic              dec_valid,
    output logic              dec_is_ext,
    output logic [ADDR_W-1:0] dec_addr,
    output logic              ex_valid,
    output logic              ex_is_ext,
    output logic [ADDR_W-1:0] ex_addr,
    output logic [WORD_W-1:0] ex_opcode,
    output logic [WORD_W-1:0] ex_ext_word,
    output logic              ex_done
);
    logic              run;
    logic              take;
    logic              f_req;
    logic [ADDR_W-1:0] f_addr;
    logic              d_v;
    slot_tag_e         d_t;
    logic [ADDR_W-1:0] d_a;
    logic              e_done;

    // Run only in the normal state; branch only on a completing slot.
    always_comb begin
        run  = is_normal(pstate);
        take = e_done && branch_taken;
    end

    ipipe_fetch #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .redirect    (take),
        .redirect_pc (branch_target),
        .commit_en   (e_done),
        .commit_addr (ex_addr),
        .fetch_addr  (f_addr),
        .fetch_req   (f_req)
    );

    ipipe_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .flush         (take),
        .fetch_req     (f_req),
        .fetch_addr    (f_addr),
        .two_word_hint (dec_two_word),
        .d_valid       (d_v),
        .d_tag         (d_t),
        .d_addr        (d_a)
    );

    ipipe_exec #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .flush         (take),
        .d_valid       (d_v),
        .d_tag         (d_t),
        .d_addr        (d_a),
        .d_word        (imem_rdata),
        .two_word_hint (dec_two_word),
        .e_valid       (ex_valid),
        .e_is_ext      (ex_is_ext),
        .e_addr        (ex_addr),
        .e_opcode      (ex_opcode),
        .e_ext_word    (ex_ext_word),
        .e_done        (e_done)
    );

    // Port view of fetch and decode stages.
    always_comb begin
        imem_addr  = f_addr;
        imem_rd    = f_req;
        dec_valid  = d_v && run;
        dec_is_ext = d_t == TAG_EXT;
        dec_addr   = d_a;
        ex_done    = e_done;
    end

endmodule

// File: rtl/ipipe_seq_chk.sv
// Module: property checker for ipipe_seq, attached with bind below.
// Assumes: it sees only the top-level ports of the sequencer.
module ipipe_seq_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        pstate,
    input logic [ADDR_W-1:0] imem_addr,
    input logic              imem_rd,
    input logic              dec_two_word,
    input logic              branch_taken,
    input logic [ADDR_W-1:0] branch_target,
    input logic              dec_valid,
    input logic              dec_is_ext,
    input logic [ADDR_W-1:0] dec_addr,
    input logic              ex_valid,
    input logic              ex_is_ext,
    input logic [ADDR_W-1:0] ex_addr,
    input logic              ex_done
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic was_rst_q;

    // Remember that the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (was_rst_q) begin
            reset_state_chk: assert (!dec_valid && !ex_valid && !ex_done
                                     && imem_addr == RESET_VEC);
        end
    end

    // R2
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_rd && $past(imem_rd) && !$past(ex_done && branch_taken))
        |-> imem_addr == $past(imem_addr) + ONE);

    // R3
    fetch_to_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(imem_rd) && !$past(ex_done && branch_taken) && pstate == 3'd0)
        |-> (dec_valid && dec_addr == $past(imem_addr)));

    // R3
    dec_to_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid) && !$past(ex_done && branch_taken) && pstate == 3'd0)
        |-> (ex_valid && ex_addr == $past(dec_addr)));

    // R5
    ext_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid && !dec_is_ext && dec_two_word) && dec_valid)
        |-> dec_is_ext);

    // R6
    hint_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dec_valid && !dec_is_ext && dec_two_word) |-> !dec_is_ext);

    // R7
    opcode_then_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_is_ext && !ex_done) ##1 (pstate == 3'd0)
        |-> (ex_valid && ex_is_ext));

    // R8
    branch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_done && branch_taken) ##1 (pstate == 3'd0)
        |-> (!dec_valid && !ex_valid && imem_addr == $past(branch_target)));

    // R9
    branch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_done && branch_taken) ##1 (pstate == 3'd0)
        |-> (dec_valid && imem_addr == $past(imem_addr) + ONE));

    // R10
    resume_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pstate != 3'd0) && pstate == 3'd0) |-> (!dec_valid && !ex_valid));

endmodule

bind ipipe_seq ipipe_seq_chk #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pstate        (pstate),
    .imem_addr     (imem_addr),
    .imem_rd       (imem_rd),
    .dec_two_word  (dec_two_word),
    .branch_taken  (branch_taken),
    .branch_target (branch_target),
    .dec_valid     (dec_valid),
    .dec_is_ext    (dec_is_ext),
    .dec_addr      (dec_addr),
    .ex_valid      (ex_valid),
    .ex_is_ext     (ex_is_ext),
    .ex_addr       (ex_addr),
    .ex_done       (ex_done)
);

// File: tb/ipipe_seq_tb.sv
// Directed bench for ipipe_seq. Word encoding used by the bench program,
// bits [23:22]: 00 one-word, 01 two-word data op, 10 one-word jump to
// [15:0], 11 two-word jump whose extension word holds the target in [15:0].
module ipipe_seq_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        pstate = 3'd0;
    logic [ADDR_W-1:0] imem_addr;
    logic              imem_rd;
    logic [WORD_W-1:0] imem_rdata = '0;
    logic              dec_two_word;
    logic              branch_taken;
    logic [ADDR_W-1:0] branch_target;
    logic              dec_valid, dec_is_ext, ex_valid, ex_is_ext, ex_done;
    logic [ADDR_W-1:0] dec_addr, ex_addr;
    logic [WORD_W-1:0] ex_opcode, ex_ext_word;

    logic              force_br = 1'b0;
    logic [ADDR_W-1:0] force_tgt = '0;
    logic [WORD_W-1:0] mem [0:255];
    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    // Program memory model: one cycle read latency.
    always @(posedge clk) begin
        if (imem_rd) imem_rdata <= mem[imem_addr[7:0]];
    end

    // Environment: decoder hint and branch resolution from the bench encoding.
    logic jmp_short, jmp_long;
    assign dec_two_word  = imem_rdata[23:22] == 2'b01 || imem_rdata[23:22] == 2'b11;
    assign jmp_short     = ex_done && !ex_is_ext && ex_opcode[23:22] == 2'b10;
    assign jmp_long      = ex_done && ex_is_ext && ex_opcode[23:22] == 2'b11;
    assign branch_taken  = force_br || jmp_short || jmp_long;
    assign branch_target = force_br ? force_tgt :
                           jmp_short ? ex_opcode[15:0] : ex_ext_word[15:0];

    ipipe_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RESET_VEC('0)) u_dut (
        .clk(clk), .rst_n(rst_n), .pstate(pstate),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata),
        .dec_two_word(dec_two_word), .branch_taken(branch_taken),
        .branch_target(branch_target), .dec_valid(dec_valid),
        .dec_is_ext(dec_is_ext), .dec_addr(dec_addr), .ex_valid(ex_valid),
        .ex_is_ext(ex_is_ext), .ex_addr(ex_addr), .ex_opcode(ex_opcode),
        .ex_ext_word(ex_ext_word), .ex_done(ex_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ex(input string req, input bit v, input int a, input bit x, input bit d);
        check(req, "ex_valid", int'(ex_valid), int'(v));
        if (v) begin
            check(req, "ex_addr", int'(ex_addr), a);
            check(req, "ex_is_ext", int'(ex_is_ext), int'(x));
            check(req, "ex_done", int'(ex_done), int'(d));
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fill_linear();
        for (int i = 0; i < 256; i++) mem[i] = {8'h00, 16'(i)};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pstate = 3'd0; force_br = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    // Reset state while reset is held.
    task automatic test_reset();
        fill_linear();
        rst_n = 1'b0;
        repeat (2) tick();
        check("R1", "dec_valid", int'(dec_valid), 0);
        check("R1", "ex_valid", int'(ex_valid), 0);
        check("R1", "ex_done", int'(ex_done), 0);
        check("R1", "imem_addr", int'(imem_addr), 0);
    endtask

    // Straight-line one-word program: fill latency and steady flow.
    task automatic test_linear();
        fill_linear();
        do_reset();
        tick();
        check("R3", "dec_valid", int'(dec_valid), 1);
        check("R3", "dec_addr", int'(dec_addr), 0);
        check("R2", "imem_addr", int'(imem_addr), 1);
        check("R3", "ex_valid first cycle", int'(ex_valid), 0);
        tick();
        chk_ex("R3", 1, 0, 0, 1);
        check("R3", "ex_opcode", int'(ex_opcode), int'(mem[0]));
        for (int k = 3; k <= 10; k++) begin
            tick();
            chk_ex("R4", 1, k - 2, 0, 1);
            check("R2", "imem_addr", int'(imem_addr), k);
        end
    endtask

    // Mixed one-word and two-word program; extension words resemble opcodes.
    task automatic test_mixed();
        fill_linear();
        mem[1] = 24'h400011; mem[2] = 24'h4ABCDE;
        mem[4] = 24'h400044; mem[5] = 24'hC01234;
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            tick();
            if (k == 3) check("R5", "dec_is_ext at 2", int'(dec_is_ext), 1);
            if (k == 4) check("R6", "dec_is_ext at 3", int'(dec_is_ext), 0);
            if (k >= 2) begin
                int a = k - 2;
                chk_ex("R7", 1, a, (a == 2 || a == 5), !(a == 1 || a == 4));
                if (a == 2) begin
                    check("R5", "ex_ext_word", int'(ex_ext_word), 24'h4ABCDE);
                    check("R5", "ex_opcode", int'(ex_opcode), 24'h400011);
                end
                if (a == 3 || a == 6) check("R6", "ex_is_ext", int'(ex_is_ext), 0);
            end
        end
    endtask

    // One-word jump: flush and refill timing.
    task automatic test_jump_short();
        fill_linear();
        mem[1] = 24'h800020;
        do_reset();
        repeat (3) tick();
        chk_ex("R8", 1, 1, 0, 1);
        tick();
        check("R8", "imem_addr target", int'(imem_addr), 32'h20);
        check("R8", "dec_valid flushed", int'(dec_valid), 0);
        check("R8", "ex_valid flushed", int'(ex_valid), 0);
        tick();
        check("R8", "ex_valid gap", int'(ex_valid), 0);
        check("R8", "dec_addr", int'(dec_addr), 32'h20);
        tick();
        chk_ex("R8", 1, 32'h20, 0, 1);
        tick();
        chk_ex("R8", 1, 32'h21, 0, 1);
    endtask

    // Two-word jump; a forced request on its opcode slot must be ignored.
    task automatic test_jump_long();
        fill_linear();
        mem[0] = 24'hC00000; mem[1] = 24'h000030;
        do_reset();
        repeat (2) tick();
        chk_ex("R7", 1, 0, 0, 0);
        check("R9", "imem_addr before", int'(imem_addr), 2);
        force_tgt = 16'h0050; force_br = 1'b1;
        tick();
        force_br = 1'b0;
        check("R9", "imem_addr sequential", int'(imem_addr), 3);
        check("R9", "dec_valid kept", int'(dec_valid), 1);
        check("R9", "dec_addr kept", int'(dec_addr), 2);
        chk_ex("R7", 1, 1, 1, 1);
        tick();
        check("R8", "imem_addr long target", int'(imem_addr), 32'h30);
        check("R8", "ex_valid flushed", int'(ex_valid), 0);
        repeat (2) tick();
        chk_ex("R8", 1, 32'h30, 0, 1);
    endtask

    // Non-normal states silence the pipeline; restart after last completion.
    task automatic test_states();
        fill_linear();
        do_reset();
        repeat (4) tick();
        chk_ex("R4", 1, 2, 0, 1);
        pstate = 3'd3;
        #1;
        check("R10", "ex_valid wait", int'(ex_valid), 0);
        check("R10", "ex_done wait", int'(ex_done), 0);
        check("R10", "imem_rd wait", int'(imem_rd), 0);
        for (int s = 1; s <= 4; s++) begin
            tick();
            pstate = 3'(s);
            #1;
            check("R10", "dec_valid halted", int'(dec_valid), 0);
            check("R10", "ex_valid halted", int'(ex_valid), 0);
            check("R10", "imem_rd halted", int'(imem_rd), 0);
        end
        tick();
        pstate = 3'd0;
        #1;
        check("R11", "imem_addr restart", int'(imem_addr), 2);
        check("R10", "ex_valid on return", int'(ex_valid), 0);
        check("R10", "dec_valid on return", int'(dec_valid), 0);
        tick();
        check("R11", "dec_addr restart", int'(dec_addr), 2);
        tick();
        chk_ex("R11", 1, 2, 0, 1);
        tick();
        chk_ex("R11", 1, 3, 0, 1);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_linear();
        test_mixed();
        test_jump_short();
        test_jump_long();
        test_states();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule